// File: doc/BRIEF.md
# Fractional-N Clock Divider with Phase Accumulator

This block divides a fast input clock by a ratio whose long-run average lies between two integers. Each output period lasts either `n_int` or `n_int + 1` input cycles. A fractional phase accumulator of `FRAC_W` bits makes that choice once per period. At the end of every period the accumulator adds the fractional word `n_frac` to its residue. When the sum overflows the full-scale value `2^FRAC_W`, a carry is produced, the residue wraps, and the next period takes one extra input cycle. Over many periods the mean modulus is `n_int + n_frac / 2^FRAC_W`, so the smallest frequency step is set by one LSB of `n_frac`.

The divided output is a pulse one input cycle wide, asserted on the last cycle of each period. It is meant to feed a phase comparator against a reference clock. The current carry and the residue are brought out for observation, because the residue tracks the instantaneous phase error that a compensation path could use. There is no streaming data path. All pins are plain level-sampled control and status signals, with no handshake and no back-pressure.

Top module: `frac_n_divider`

## Requirements
- R1: With no carry pending, a period lasts exactly `max(n_int,2)` input cycles, and `div_pulse` is high for only the last cycle of each period.
- R2: On each `div_pulse` cycle the residue becomes `(residue + n_frac) mod 2^FRAC_W`. On every other cycle the residue holds its value.
- R3: `carry` becomes 1 on a pulse cycle exactly when `residue + n_frac >= 2^FRAC_W`, and 0 otherwise. The value holds until the next pulse.
- R4: The period that follows a pulse setting `carry` to 1 lasts `max(n_int,2) + 1` input cycles.
- R5: With `n_int = 4` and `n_frac = 2^FRAC_W / 4`, every four consecutive periods after the first contain three 4-cycle periods and one 5-cycle period.
- R6: With `n_frac = 0`, `carry` never asserts and every period lasts `max(n_int,2)` cycles.
- R7: `n_int` and `n_frac` are used only on the pulse cycle (and during reset). A change in the middle of a period does not alter the length of that period. It takes effect from the next period.
- R8: Values of `n_int` below 2 are treated as 2.
- R9: Synchronous active-high `rst` clears the residue and `carry` to 0 and starts a fresh period of `max(n_int,2)` cycles, counted from the first cycle after reset.
- R10: Over `2^FRAC_W` consecutive periods following the first, the total input-cycle count is `2^FRAC_W * n_int + n_frac`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| n_int | input | INT_W | Integer part of the modulus (values below 2 are treated as 2) |
| n_frac | input | FRAC_W | Fractional part of the modulus, in units of 2^-FRAC_W |
| div_pulse | output | 1 | One-cycle pulse on the last input cycle of each period |
| carry | output | 1 | Accumulator overflow from the latest pulse; it lengthens the current period |
| residue | output | FRAC_W | Accumulator residue (the instantaneous phase error) |

## Verification
The bench targets the periods next to the carry. An off-by-one in the swallow path would make the 5-cycle period land one period early or late, or last 6 cycles, which breaks the three-to-one pattern and the total-cycle count over a full accumulator cycle. An overflow compare written as `>` rather than `>=` would lose the carry when the sum equals full scale exactly, as it does every fourth period with a quarter-scale word. A divider that reloads its count from the live `n_int` would truncate a running period when the ratio is changed mid-period, and a missing clamp would run the counter away when `n_int` is below 2. The reset scenario confirms that no stale residue survives and that the first period is uncarried.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  // Smallest modulus the counter can realise with a one-cycle pulse
  localparam int unsigned FND_MIN_MOD = 2;
endpackage

// File: rtl/fnd_phase_acc.sv
module fnd_phase_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              carry_nx_o,
  output logic              carry_o,
  output logic [FRAC_W-1:0] residue_o
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] residue_q;
  logic              carry_q;

  // One extra bit catches the overflow past full scale
  assign sum        = {1'b0, residue_q} + {1'b0, frac_in};
  assign carry_nx_o = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      residue_q <= '0;
      carry_q   <= 1'b0;
    end else if (step) begin
      residue_q <= sum[FRAC_W-1:0];
      carry_q   <= sum[FRAC_W];
    end
  end

  assign carry_o   = carry_q;
  assign residue_o = residue_q;

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(residue_q));                                 // R2
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
    step |=> (carry_q == (residue_q < $past(residue_q))));         // R3
  AST_ZERO_FRAC: assert property (@(posedge clk) disable iff (rst)
    (step && frac_in == '0) |=> !carry_q);                         // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (residue_q == '0 && !carry_q));                        // R9
endmodule

// File: rtl/fnd_mod_counter.sv
module fnd_mod_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q;

  assign term_o = (cnt_q == '0);

  // Counts down to zero, then reloads the length of the next period minus one
  always_ff @(posedge clk) begin
    if (rst || term_o) cnt_q <= load_val;
    else               cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    term_o |=> !term_o);                                           // R1
endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  n_int,
  input  logic [FRAC_W-1:0] n_frac,
  output logic              div_pulse,
  output logic              carry,
  output logic [FRAC_W-1:0] residue
);
  import fnd_pkg::*;

  localparam int unsigned CNT_W = INT_W + 1;
  localparam logic [INT_W-1:0] MIN_MOD_V = INT_W'(FND_MIN_MOD);

  logic [INT_W-1:0] n_eff;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             carry_nx;
  logic             term;

  // Clamp below the smallest realisable modulus
  assign n_eff = (n_int < MIN_MOD_V) ? MIN_MOD_V : n_int;

  // Next period length minus one; a carry swallows one more input cycle
  assign load_val = {1'b0, n_eff} + CNT_W'(carry_nx & ~rst) - CNT_W'(1);

  fnd_mod_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load_val (load_val),
    .cnt_o    (cnt),
    .term_o   (term)
  );

  fnd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .step       (term),
    .frac_in    (n_frac),
    .carry_nx_o (carry_nx),
    .carry_o    (carry),
    .residue_o  (residue)
  );

  assign div_pulse = term;

  AST_LONG_PERIOD: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> (cnt == {1'b0, $past(n_eff)} + CNT_W'(carry) - CNT_W'(1))); // R4
  AST_FRESH_START: assert property (@(posedge clk)
    rst |=> (cnt == {1'b0, $past(n_eff)} - CNT_W'(1)));            // R9
endmodule

// File: tb/frac_n_divider_bench.sv
module frac_n_divider_bench;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 8;
  localparam int FULL   = 1 << FRAC_W;

  logic              clk = 1'b0;
  logic              rst = 1'b0;
  logic [INT_W-1:0]  n_int = 8'd4;
  logic [FRAC_W-1:0] n_frac = '0;
  logic              div_pulse;
  logic              carry;
  logic [FRAC_W-1:0] residue;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  frac_n_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac_n_divider (
    .clk(clk), .rst(rst), .n_int(n_int), .n_frac(n_frac),
    .div_pulse(div_pulse), .carry(carry), .residue(residue)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // Behavioural reference: period length and position, counted upward
  int m_res = 0, m_cy = 0, m_len = 2, m_pos = 0;
  bit armed = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      m_res = 0; m_cy = 0; m_len = eff(int'(n_int)); m_pos = 0; armed = 1'b1;
    end else if (m_pos == m_len - 1) begin
      int s;
      s = m_res + int'(n_frac);
      m_cy = (s >= FULL) ? 1 : 0;
      m_res = s % FULL;
      m_len = eff(int'(n_int)) + m_cy;
      m_pos = 0;
    end else begin
      m_pos++;
    end
  end

  // Per-clock comparison and period measurement, away from the active edge
  int lens[$];
  int since = 0;
  event got_pulse;
  always @(negedge clk) begin
    if (armed) begin
      chk(div_pulse == (m_pos == m_len - 1), "R1 pulse", div_pulse, m_pos == m_len - 1);
      chk(int'(residue) == m_res, "R2 residue", residue, m_res);
      chk(int'(carry) == m_cy, "R3 carry", carry, m_cy);
    end
    if (rst) since = 0;
    else begin
      since++;
      if (div_pulse) begin
        lens.push_back(since);
        since = 0;
        -> got_pulse;
      end
    end
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      summary_and_end();
    end
  end

  task automatic do_reset(input int ni, input int nf);
    @(posedge clk); #1;
    n_int = INT_W'(ni); n_frac = FRAC_W'(nf); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    lens.delete();
  endtask

  task automatic wait_pulses(input int n);
    repeat (n) @(got_pulse);
  endtask

  initial begin
    // R9: reset state
    @(posedge clk); #1; n_int = 8'd4; n_frac = '0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(residue == '0, "R9 residue after reset", residue, 0);
    chk(carry == 1'b0, "R9 carry after reset", carry, 0);
    chk(div_pulse == 1'b0, "R9 no pulse in reset", div_pulse, 0);
    @(posedge clk); #1 rst = 1'b0; lens.delete();
    wait_pulses(6);
    chk(lens[0] == 4, "R9 first period", lens[0], 4);
    for (int i = 1; i < 6; i++) chk(lens[i] == 4, "R6 plain divide", lens[i], 4);

    // R5 / R4: quarter-scale word
    do_reset(4, FULL / 4);
    wait_pulses(9);
    begin
      int fives = 0, tot = 0;
      for (int i = 1; i < 9; i++) begin
        tot += lens[i];
        if (lens[i] == 5) fives++;
      end
      chk(fives == 2, "R5 count of long periods", fives, 2);
      chk(tot == 34, "R5 cycles in 8 periods", tot, 34);
      chk(lens[4] == 5, "R4 swallowed period", lens[4], 5);
    end

    // R10: average modulus over a full accumulator cycle
    do_reset(6, 37);
    wait_pulses(FULL + 1);
    begin
      int tot = 0;
      for (int i = 1; i <= FULL; i++) tot += lens[i];
      chk(tot == FULL * 6 + 37, "R10 total cycles", tot, FULL * 6 + 37);
    end

    // R8: clamp below two
    do_reset(1, 0);
    wait_pulses(4);
    chk(lens[0] == 2, "R8 n_int=1", lens[0], 2);
    chk(lens[3] == 2, "R8 n_int=1 later", lens[3], 2);
    do_reset(0, 0);
    wait_pulses(3);
    chk(lens[2] == 2, "R8 n_int=0", lens[2], 2);

    // R7: mid-period change of the ratio
    do_reset(10, 0);
    wait_pulses(1);
    repeat (3) @(posedge clk);
    #1 n_int = 8'd3; n_frac = 8'd200;
    wait_pulses(2);
    chk(lens[1] == 10, "R7 running period kept", lens[1], 10);
    chk(lens[2] == 3, "R7 new ratio next period", lens[2], 3);

    // R4 at the top of the range
    do_reset(255, 255);
    wait_pulses(3);
    chk(lens[1] == 255, "R1 long period no carry", lens[1], 255);
    chk(lens[2] == 256, "R4 carry at max modulus", lens[2], 256);

    repeat (3) @(posedge clk);
    summary_and_end();
  end
endmodule